// File: doc/BRIEF.md
# Dual-CPU Shared Memory Select Logic

This block produces the active-low strobes for a boot ROM and a common RAM that two processors share, and the bank selects for four private RAM banks that only the second (sub) processor reaches. A source selector picks which processor drives the shared memories. The sub processor's decoded strobes pass through by default. The main processor takes over when it asks for the boot ROM. It can also take the common RAM, but only when the sub processor is held in reset and has acknowledged.

The shared memories see one address bus. For main-processor ROM reads, one address line is forced high, so the main boot code sits at ROM offset 0x1000. A clocked owner flag shows which processor held the shared memories on the previous clock.

Top module: `dual_cpu_mem_sel`

## Requirements
- R1: With neither main request low (`main_rom_req_ni`=1 and `main_ram_req_ni`=1), the shared strobes and `mem_addr_o` come from the sub-CPU decoder, and `mem_addr_o` = `sub_addr_i[12:0]`.
- R2: With `main_rom_req_ni`=0, the main CPU owns the ROM. `rom_ce_no`=0 and `rom_oe_no`=`main_rd_ni`. `mem_addr_o` = `main_addr_i` with bit 12 forced to 1. Sub-CPU strobes have no effect on the shared outputs.
- R3: The main CPU owns the common RAM only when all of these hold: `main_ram_req_ni`=0, `sub_rst_i`=1 and `sub_ack_ni`=0. In that case `ram_cs_no`=0, `ram_oe_no`=`main_rd_ni`, `ram_we_no`=`main_wr_ni`, `rom_ce_no`=1 and `mem_addr_o`=`main_addr_i`. If any condition fails, the R1 sub path applies.
- R4: When both main requests are low, the ROM request wins. The RAM strobes then all stay at 1.
- R5: On the sub path, `rom_ce_no`=0 exactly when `sub_addr_i[15:13]`=0. `rom_oe_no`=0 only when that holds and `sub_mreq_ni`=0 and `sub_rd_ni`=0.
- R6: On the sub path, `ram_cs_no`=0 exactly when `sub_addr_i[15:13]`=3'b001. `ram_oe_no`=0 needs that together with `sub_mreq_ni`=0 and `sub_rd_ni`=0. `ram_we_no`=0 needs it together with `sub_mreq_ni`=0 and `sub_wr_ni`=0.
- R7: `loc_cs_no[k]`=0 only when `sub_addr_i[15:13]`=3'b010, `sub_addr_i[12:11]`=k, `sub_mreq_ni`=0 and either `sub_rd_ni` or `sub_wr_ni` is 0. At most one bank select is low at a time. The bank selects do not depend on the owner.
- R8: A sub address at or above 0x6000 asserts no shared strobe and no bank select.
- R9: `grant_main_o` is 0 during reset. On each clock it loads 1 if the main CPU owned the shared memories (per R2 or R3) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the owner flag |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_rom_req_ni | input | 1 | Main CPU boot-ROM request, active low |
| main_ram_req_ni | input | 1 | Main CPU common-RAM request, active low |
| main_rd_ni | input | 1 | Main CPU read strobe, active low |
| main_wr_ni | input | 1 | Main CPU write strobe, active low |
| main_addr_i | input | 13 | Main CPU address into shared memory |
| sub_rst_i | input | 1 | Sub CPU reset level (1 = held) |
| sub_ack_ni | input | 1 | Sub CPU acknowledge, active low |
| sub_addr_i | input | 16 | Sub CPU address |
| sub_mreq_ni | input | 1 | Sub CPU memory request, active low |
| sub_rd_ni | input | 1 | Sub CPU read strobe, active low |
| sub_wr_ni | input | 1 | Sub CPU write strobe, active low |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| rom_oe_no | output | 1 | ROM output enable, active low |
| ram_cs_no | output | 1 | Common RAM chip select, active low |
| ram_oe_no | output | 1 | Common RAM output enable, active low |
| ram_we_no | output | 1 | Common RAM write enable, active low |
| mem_addr_o | output | 13 | Address to the shared memories |
| loc_cs_no | output | 4 | Local RAM bank selects, active low |
| grant_main_o | output | 1 | Registered main-CPU ownership flag |

## Verification
The bench targets four kinds of mistake:
- **RAM handover.** It drops each of the three handover conditions in turn. A design that hands over on the request alone would let the main CPU drive the RAM while the sub CPU runs.
- **Ownership leaks.** It drives a sub-CPU read at the same moment the main CPU owns the ROM. A design that leaks sub strobes would show a ROM output enable that ignores the main read line. It also checks the boot offset, which a missing address force would place at 0x0034 instead of 0x1034.
- **Decode edges.** It probes region and bank edges (0x1FFF, 0x2000, 0x4000, 0x5800, 0x6000) and bank accesses with no memory request. A loose decode would then assert extra selects.
- **Priority and flag timing.** It asserts both main requests at once, and times the owner flag one clock behind the request.

// File: rtl/mem_sel_pkg.sv
package mem_sel_pkg;
  typedef enum logic {
    OWN_SUB  = 1'b0,
    OWN_MAIN = 1'b1
  } owner_e;

  typedef struct packed {
    logic rom_ce_n;
    logic rom_oe_n;
    logic ram_cs_n;
    logic ram_oe_n;
    logic ram_we_n;
  } shr_strb_t;

  localparam shr_strb_t STRB_IDLE = '{default: 1'b1};
endpackage

// File: rtl/sub_addr_dec.sv
module sub_addr_dec
  import mem_sel_pkg::*;
#(
  parameter int AW     = 16,
  parameter int SHR_AW = 13,
  parameter int LOC_N  = 4,
  parameter int LOC_AW = 11
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             mreq_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  output shr_strb_t        strb_o,
  output logic [LOC_N-1:0] loc_cs_no
);
  localparam int RW     = AW - SHR_AW;
  localparam int LOC_IW = SHR_AW - LOC_AW;

  logic [RW-1:0]     region;
  logic [LOC_IW-1:0] bank_idx;
  logic rd_acc, wr_acc, rom_hit, ram_hit, loc_hit;

  assign region   = addr_i[AW-1:SHR_AW];
  assign bank_idx = addr_i[SHR_AW-1:LOC_AW];
  assign rd_acc   = !mreq_ni && !rd_ni;
  assign wr_acc   = !mreq_ni && !wr_ni;
  assign rom_hit  = (region == RW'(0));
  assign ram_hit  = (region == RW'(1));
  assign loc_hit  = (region == RW'(2)) && (rd_acc || wr_acc);

  always_comb begin
    strb_o          = STRB_IDLE;
    strb_o.rom_ce_n = !rom_hit;
    strb_o.rom_oe_n = !(rom_hit && rd_acc);
    strb_o.ram_cs_n = !ram_hit;
    strb_o.ram_oe_n = !(ram_hit && rd_acc);
    strb_o.ram_we_n = !(ram_hit && wr_acc);
  end

  for (genvar g = 0; g < LOC_N; g++) begin : g_bank
    assign loc_cs_no[g] = !(loc_hit && (bank_idx == LOC_IW'(g)));
  end
endmodule

// File: rtl/main_path.sv
module main_path
  import mem_sel_pkg::*;
#(
  parameter int SHR_AW   = 13,
  parameter int BOOT_BIT = 12
) (
  input  logic              rom_req_ni,
  input  logic              ram_req_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              sub_rst_i,
  input  logic              sub_ack_ni,
  input  logic [SHR_AW-1:0] addr_i,
  output logic              rom_sel_o,
  output logic              ram_sel_o,
  output shr_strb_t         strb_o,
  output logic [SHR_AW-1:0] addr_o
);
  assign rom_sel_o = !rom_req_ni;
  // ROM request has priority; RAM needs sub held in reset and acknowledged
  assign ram_sel_o = rom_req_ni && !ram_req_ni && sub_rst_i && !sub_ack_ni;

  always_comb begin
    strb_o          = STRB_IDLE;
    strb_o.rom_ce_n = !rom_sel_o;
    strb_o.rom_oe_n = !(rom_sel_o && !rd_ni);
    strb_o.ram_cs_n = !ram_sel_o;
    strb_o.ram_oe_n = !(ram_sel_o && !rd_ni);
    strb_o.ram_we_n = !(ram_sel_o && !wr_ni);
    addr_o          = addr_i;
    if (rom_sel_o) addr_o[BOOT_BIT] = 1'b1;
  end
endmodule

// File: rtl/dual_cpu_mem_sel.sv
module dual_cpu_mem_sel
  import mem_sel_pkg::*;
#(
  parameter int AW       = 16,
  parameter int SHR_AW   = 13,
  parameter int BOOT_BIT = 12,
  parameter int LOC_N    = 4,
  parameter int LOC_AW   = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              main_rom_req_ni,
  input  logic              main_ram_req_ni,
  input  logic              main_rd_ni,
  input  logic              main_wr_ni,
  input  logic [SHR_AW-1:0] main_addr_i,
  input  logic              sub_rst_i,
  input  logic              sub_ack_ni,
  input  logic [AW-1:0]     sub_addr_i,
  input  logic              sub_mreq_ni,
  input  logic              sub_rd_ni,
  input  logic              sub_wr_ni,
  output logic              rom_ce_no,
  output logic              rom_oe_no,
  output logic              ram_cs_no,
  output logic              ram_oe_no,
  output logic              ram_we_no,
  output logic [SHR_AW-1:0] mem_addr_o,
  output logic [LOC_N-1:0]  loc_cs_no,
  output logic              grant_main_o
);
  shr_strb_t         sub_strb, main_strb, shr_strb;
  logic [SHR_AW-1:0] main_addr_m;
  logic              main_rom_sel, main_ram_sel;
  owner_e            owner_d, owner_q;

  sub_addr_dec #(
    .AW(AW), .SHR_AW(SHR_AW), .LOC_N(LOC_N), .LOC_AW(LOC_AW)
  ) u_sub_dec (
    .addr_i   (sub_addr_i),
    .mreq_ni  (sub_mreq_ni),
    .rd_ni    (sub_rd_ni),
    .wr_ni    (sub_wr_ni),
    .strb_o   (sub_strb),
    .loc_cs_no(loc_cs_no)
  );

  main_path #(
    .SHR_AW(SHR_AW), .BOOT_BIT(BOOT_BIT)
  ) u_main (
    .rom_req_ni(main_rom_req_ni),
    .ram_req_ni(main_ram_req_ni),
    .rd_ni     (main_rd_ni),
    .wr_ni     (main_wr_ni),
    .sub_rst_i (sub_rst_i),
    .sub_ack_ni(sub_ack_ni),
    .addr_i    (main_addr_i),
    .rom_sel_o (main_rom_sel),
    .ram_sel_o (main_ram_sel),
    .strb_o    (main_strb),
    .addr_o    (main_addr_m)
  );

  assign owner_d    = (main_rom_sel || main_ram_sel) ? OWN_MAIN : OWN_SUB;
  assign shr_strb   = (owner_d == OWN_MAIN) ? main_strb : sub_strb;
  assign mem_addr_o = (owner_d == OWN_MAIN) ? main_addr_m : sub_addr_i[SHR_AW-1:0];
  assign rom_ce_no  = shr_strb.rom_ce_n;
  assign rom_oe_no  = shr_strb.rom_oe_n;
  assign ram_cs_no  = shr_strb.ram_cs_n;
  assign ram_oe_no  = shr_strb.ram_oe_n;
  assign ram_we_no  = shr_strb.ram_we_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_SUB;
    else         owner_q <= owner_d;
  end
  assign grant_main_o = (owner_q == OWN_MAIN);

  assert_sub_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_rom_req_ni && main_ram_req_ni) |-> (mem_addr_o == sub_addr_i[SHR_AW-1:0]));

  assert_main_rom_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_rom_req_ni |-> (!rom_ce_no && rom_oe_no == main_rd_ni && mem_addr_o[BOOT_BIT]));

  assert_main_ram_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_rom_req_ni && !main_ram_req_ni && sub_rst_i && !sub_ack_ni)
      |-> (!ram_cs_no && ram_we_no == main_wr_ni && ram_oe_no == main_rd_ni && rom_ce_no));

  assert_rom_prio_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_rom_req_ni |-> (ram_cs_no && ram_oe_no && ram_we_no));

  assert_loc_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~loc_cs_no));

  assert_loc_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_mreq_ni |-> (&loc_cs_no));

  assert_grant_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_rom_req_ni |=> grant_main_o);

  assert_grant_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_rom_req_ni && main_ram_req_ni) |=> !grant_main_o);
endmodule

// File: tb/dual_cpu_mem_sel_tb.sv
module dual_cpu_mem_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_rom_n = 1'b1, m_ram_n = 1'b1, m_rd_n = 1'b1, m_wr_n = 1'b1;
  logic [12:0] m_addr = '0;
  logic        s_rst = 1'b0, s_ack_n = 1'b1;
  logic [15:0] s_addr = 16'h8000;
  logic        s_mreq_n = 1'b1, s_rd_n = 1'b1, s_wr_n = 1'b1;
  logic        rom_ce_n, rom_oe_n, ram_cs_n, ram_oe_n, ram_we_n, grant;
  logic [12:0] mem_addr;
  logic [3:0]  loc_n;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dual_cpu_mem_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .main_rom_req_ni(m_rom_n), .main_ram_req_ni(m_ram_n),
    .main_rd_ni(m_rd_n), .main_wr_ni(m_wr_n), .main_addr_i(m_addr),
    .sub_rst_i(s_rst), .sub_ack_ni(s_ack_n), .sub_addr_i(s_addr),
    .sub_mreq_ni(s_mreq_n), .sub_rd_ni(s_rd_n), .sub_wr_ni(s_wr_n),
    .rom_ce_no(rom_ce_n), .rom_oe_no(rom_oe_n), .ram_cs_no(ram_cs_n),
    .ram_oe_no(ram_oe_n), .ram_we_no(ram_we_n), .mem_addr_o(mem_addr),
    .loc_cs_no(loc_n), .grant_main_o(grant)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // shared strobes packed as {rom_ce, rom_oe, ram_cs, ram_oe, ram_we}
  function automatic int strb();
    return {rom_ce_n, rom_oe_n, ram_cs_n, ram_oe_n, ram_we_n};
  endfunction

  task automatic sub_drive(logic [15:0] a, logic mreq_n, logic rd_n, logic wr_n);
    @(negedge clk);
    s_addr = a; s_mreq_n = mreq_n; s_rd_n = rd_n; s_wr_n = wr_n;
    #1;
  endtask

  task automatic main_idle();
    m_rom_n = 1'b1; m_ram_n = 1'b1; m_rd_n = 1'b1; m_wr_n = 1'b1;
    s_rst = 1'b0; s_ack_n = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    chk("R9", "grant in reset", int'(grant), 0);
    chk("R8", "strobes idle at 0x8000", strb(), 5'b11111);
    chk("R8", "banks idle at 0x8000", int'(loc_n), 4'hF);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_sub_rom();
    sub_drive(16'h0123, 1'b0, 1'b0, 1'b1);
    chk("R5", "sub rom read strobes", strb(), 5'b00111);
    chk("R1", "sub addr passes", int'(mem_addr), 13'h0123);
    sub_drive(16'h1FFF, 1'b1, 1'b0, 1'b1);
    chk("R5", "rom ce without mreq", strb(), 5'b01111);
    sub_drive(16'h1FFF, 1'b0, 1'b1, 1'b0);
    chk("R5", "rom write no oe", strb(), 5'b01111);
  endtask

  task automatic t_sub_ram();
    sub_drive(16'h2ABC, 1'b0, 1'b1, 1'b0);
    chk("R6", "ram write", strb(), 5'b11010);
    chk("R1", "ram addr", int'(mem_addr), 13'h0ABC);
    sub_drive(16'h3FFF, 1'b0, 1'b0, 1'b1);
    chk("R6", "ram read", strb(), 5'b11001);
    sub_drive(16'h2000, 1'b1, 1'b0, 1'b0);
    chk("R6", "ram no mreq", strb(), 5'b11011);
  endtask

  task automatic t_local();
    logic [15:0] base [4] = '{16'h4000, 16'h4800, 16'h5012, 16'h5800};
    for (int k = 0; k < 4; k++) begin
      sub_drive(base[k], 1'b0, k[0], !k[0]);
      chk("R7", $sformatf("bank %0d select", k), int'(loc_n), int'(~(4'b1 << k)) & 4'hF);
      chk("R7", "bank no shared strobe", strb(), 5'b11111);
    end
    sub_drive(16'h4800, 1'b1, 1'b0, 1'b1);
    chk("R7", "bank without mreq", int'(loc_n), 4'hF);
    sub_drive(16'h5800, 1'b0, 1'b1, 1'b1);
    chk("R7", "bank without rd/wr", int'(loc_n), 4'hF);
  endtask

  task automatic t_unmapped();
    sub_drive(16'h6000, 1'b0, 1'b0, 1'b1);
    chk("R8", "0x6000 strobes", strb(), 5'b11111);
    chk("R8", "0x6000 banks", int'(loc_n), 4'hF);
    sub_drive(16'hFFFF, 1'b0, 1'b1, 1'b0);
    chk("R8", "0xFFFF strobes", strb(), 5'b11111);
  endtask

  task automatic t_main_rom();
    @(negedge clk);
    m_addr = 13'h0034; m_rom_n = 1'b0; m_rd_n = 1'b0;
    s_addr = 16'h0010; s_mreq_n = 1'b0; s_rd_n = 1'b0; s_wr_n = 1'b1;
    #1;
    chk("R2", "main rom read", strb(), 5'b00111);
    chk("R2", "boot offset addr", int'(mem_addr), 13'h1034);
    m_rd_n = 1'b1; #1;
    chk("R2", "sub read ignored", strb(), 5'b01111);
    @(posedge clk); #1;
    chk("R9", "grant after rom req", int'(grant), 1);
    @(negedge clk) main_idle(); s_mreq_n = 1'b1;
    @(posedge clk); #1;
    chk("R9", "grant released", int'(grant), 0);
  endtask

  task automatic t_main_ram();
    @(negedge clk);
    s_addr = 16'h2100; s_mreq_n = 1'b0; s_rd_n = 1'b0; s_wr_n = 1'b1;
    m_addr = 13'h0055; m_ram_n = 1'b0; m_wr_n = 1'b0; s_rst = 1'b1; s_ack_n = 1'b0;
    #1;
    chk("R3", "main ram write", strb(), 5'b11010);
    chk("R3", "main ram addr", int'(mem_addr), 13'h0055);
    @(posedge clk); #1;
    chk("R9", "grant after ram req", int'(grant), 1);
    @(negedge clk) s_ack_n = 1'b1; #1;
    chk("R3", "no ack -> sub path", strb(), 5'b11001);
    chk("R3", "no ack addr", int'(mem_addr), 13'h0100);
    s_ack_n = 1'b0; s_rst = 1'b0; #1;
    chk("R3", "sub running -> sub path", strb(), 5'b11001);
    s_rst = 1'b1; m_ram_n = 1'b1; #1;
    chk("R3", "no req -> sub path", strb(), 5'b11001);
    @(posedge clk); #1;
    chk("R9", "no grant on sub path", int'(grant), 0);
    @(negedge clk) main_idle(); s_mreq_n = 1'b1;
  endtask

  task automatic t_priority();
    @(negedge clk);
    m_addr = 13'h0002; m_rom_n = 1'b0; m_ram_n = 1'b0; m_rd_n = 1'b0; m_wr_n = 1'b0;
    s_rst = 1'b1; s_ack_n = 1'b0;
    #1;
    chk("R4", "rom wins", strb(), 5'b00111);
    chk("R4", "rom offset", int'(mem_addr), 13'h1002);
    @(negedge clk) main_idle();
  endtask

  initial begin
    t_reset();
    t_sub_rom();
    t_sub_ram();
    t_local();
    t_unmapped();
    t_main_rom();
    t_main_ram();
    t_priority();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule